// File: doc/BRIEF.md
# Iterative Radix-16 Significand Multiplier

This block multiplies the significands of two double-width binary floating-point operands by repeated shift-and-add. An operand is presented as its 52-bit fraction and its 11-bit biased exponent. Operands with a nonzero exponent get an implicit leading one. An operand with a zero exponent is a subnormal. It is brought to normal form one shift per clock before multiplication begins, and the working exponent is lowered by one for each shift.

The multiply loop takes four multiplier bits per clock. The bits that leave the bottom of the accumulator are folded into a sticky flag. After the loop, the product is aligned so that its leading one sits at the top bit of the result field. The block reports the working exponent, the 53 result bits, a guard bit and a sticky bit, which a rounding stage downstream can use. Rounding, zero, infinity and NaN handling belong to that other logic.

A single start cycle launches an operation. Busy stays high until the one-cycle done pulse, and the outputs hold their values until the next accepted start.

Top module: `r16_sig_mul`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, busy and done are both low. A reset in the middle of an operation returns the block to idle.
- R2: start is accepted only while busy is low. busy is high from the cycle after an accepted start through the done cycle. A start that arrives while busy is ignored and does not change the result or the latency.
- R3: done is high for exactly one cycle. prod_mant, prod_exp, guard and sticky keep their values after done until the next accepted start.
- R4: When both exponents are nonzero, done is seen 17 clock cycles after the edge that accepts start.
- R5: An operand whose exponent field is nonzero uses the significand {1, fraction}.
- R6: An operand whose exponent field is zero starts as {fraction, 0} and is shifted left until bit 52 is set. Both operands shift in the same cycles. Each shift lowers the working exponent by one and adds one cycle to the R4 latency, so the latency is 17 + max(shifts of a, shifts of b).
- R7: prod_exp is a 14-bit two's-complement value. It equals exp_a + exp_b - 1023, minus the total pre-normalization shifts, plus one when the significand product is 2 or more. No clamping is applied.
- R8: prod_mant holds the 53 most significant bits of the exact 106-bit significand product, counted from its leading one, so prod_mant[52] is 1 at done.
- R9: guard is the product bit immediately below the least significant bit of prod_mant.
- R10: sticky is the OR of every product bit below the guard bit, including the bits dropped from the accumulator during the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (ignored while busy) |
| frac_a | input | 52 | Fraction of operand A |
| exp_a | input | 11 | Biased exponent of operand A |
| frac_b | input | 52 | Fraction of operand B |
| exp_b | input | 11 | Biased exponent of operand B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_mant | output | 53 | Normalized product significand, leading one at bit 52 |
| prod_exp | output | 14 | Working exponent, two's complement |
| guard | output | 1 | First bit below prod_mant |
| sticky | output | 1 | OR of all lower product bits |

## Verification
The assertions assume that an operand with a zero exponent always has a nonzero fraction, because a zero significand would never normalize. A guard assertion on the start inputs flags any violation. They also assume that no zero, infinite or NaN operand is presented, since those cases are resolved before this unit. Every vector in the stimulus table is a finite, nonzero value. The subnormal entries go as far as a fraction holding only its lowest bit, which gives the longest pre-normalization. A separate directed case pulses start in the middle of a run to show that the request is dropped.

// File: rtl/r16mul_pkg.sv
package r16mul_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_PRENORM  = 3'd1,
      ST_LOOP     = 3'd2,
      ST_FIX      = 3'd3,
      ST_POSTNORM = 3'd4,
      ST_DONE     = 3'd5
   } r16_state_e;
endpackage

// File: rtl/r16_prenorm.sv
module r16_prenorm #(
   parameter int FRAC_W = 52,
   localparam int MANT_W = FRAC_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic              exp_zero_i,
   input  logic              step_i,
   output logic [MANT_W-1:0] mant_o,
   output logic              ready_o,
   output logic              shift_o
);
   logic [MANT_W-1:0] mant_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mant_q <= '0;
      end else if (load_i) begin
         mant_q <= exp_zero_i ? {frac_i, 1'b0} : {1'b1, frac_i};
      end else if (step_i && !mant_q[MANT_W-1]) begin
         mant_q <= mant_q << 1;
      end
   end

   assign mant_o  = mant_q;
   assign ready_o = mant_q[MANT_W-1];
   assign shift_o = step_i && !mant_q[MANT_W-1];

   // R6: once the leading one reaches the top it stays there until a new load
   a_r6_stays_normal: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !load_i) |=> ready_o);
endmodule

// File: rtl/r16_step.sv
module r16_step #(
   parameter int MANT_W   = 53,
   parameter int DIGIT    = 4,
   parameter int GUARD_SH = 7,
   parameter int ACC_W    = 64
) (
   input  logic [ACC_W-1:0]  acc_i,
   input  logic [MANT_W-1:0] mcand_i,
   input  logic [DIGIT-1:0]  digit_i,
   output logic [ACC_W-1:0]  acc_o,
   output logic              drop_o
);
   logic [ACC_W-1:0] ext;
   logic [ACC_W-1:0] term [DIGIT];

   assign ext = ACC_W'(mcand_i);

   for (genvar j = 0; j < DIGIT; j++) begin : g_term
      assign term[j] = digit_i[j] ? (ext << (GUARD_SH + j)) : '0;
   end

   always_comb begin
      acc_o = acc_i >> DIGIT;
      for (int j = DIGIT - 1; j >= 0; j--) begin
         acc_o = acc_o + term[j];
      end
   end

   assign drop_o = |acc_i[DIGIT-1:0];
endmodule

// File: rtl/r16_sig_mul.sv
module r16_sig_mul
   import r16mul_pkg::*;
#(
   parameter int FRAC_W   = 52,
   parameter int EXP_W    = 11,
   parameter int DIGIT    = 4,
   parameter int GUARD_SH = 7,
   localparam int MANT_W  = FRAC_W + 1,
   localparam int XEXP_W  = EXP_W + 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [FRAC_W-1:0]        frac_a,
   input  logic [EXP_W-1:0]         exp_a,
   input  logic [FRAC_W-1:0]        frac_b,
   input  logic [EXP_W-1:0]         exp_b,
   output logic                     busy,
   output logic                     done,
   output logic [MANT_W-1:0]        prod_mant,
   output logic signed [XEXP_W-1:0] prod_exp,
   output logic                     guard,
   output logic                     sticky
);
   localparam int ITER    = (MANT_W + DIGIT - 1) / DIGIT;
   localparam int ACC_W   = MANT_W + GUARD_SH + DIGIT;
   localparam int LEAD    = MANT_W + GUARD_SH;
   localparam int RES_LSB = GUARD_SH + 1;
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int CNT_W   = $clog2(ITER + 1);

   if ((MANT_W - 1) % DIGIT != 0) begin : g_bad_digit
      $error("digit width must divide the fraction width");
   end
   if (GUARD_SH < 2) begin : g_bad_guard
      $error("guard shift must leave room for guard and sticky bits");
   end

   r16_state_e        state;
   logic signed [XEXP_W-1:0] exp_w;
   logic [ACC_W-1:0]  acc, acc_nxt;
   logic [MANT_W-1:0] mcand, mplier;
   logic [MANT_W-1:0] mant_a, mant_b;
   logic [CNT_W-1:0]  iter;
   logic              sticky_r, drop;
   logic              rdy_a, rdy_b, sh_a, sh_b, load, pre_step;
   logic [1:0]        nshift;

   assign load     = (state == ST_IDLE) && start;
   assign pre_step = (state == ST_PRENORM);
   assign nshift   = {1'b0, sh_a} + {1'b0, sh_b};

   r16_prenorm #(.FRAC_W(FRAC_W)) u_pre_a (
      .clk(clk), .rst_n(rst_n), .load_i(load), .frac_i(frac_a),
      .exp_zero_i(exp_a == '0), .step_i(pre_step),
      .mant_o(mant_a), .ready_o(rdy_a), .shift_o(sh_a));

   r16_prenorm #(.FRAC_W(FRAC_W)) u_pre_b (
      .clk(clk), .rst_n(rst_n), .load_i(load), .frac_i(frac_b),
      .exp_zero_i(exp_b == '0), .step_i(pre_step),
      .mant_o(mant_b), .ready_o(rdy_b), .shift_o(sh_b));

   r16_step #(.MANT_W(MANT_W), .DIGIT(DIGIT), .GUARD_SH(GUARD_SH), .ACC_W(ACC_W)) u_step (
      .acc_i(acc), .mcand_i(mcand), .digit_i(mplier[DIGIT-1:0]),
      .acc_o(acc_nxt), .drop_o(drop));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         exp_w    <= '0;
         acc      <= '0;
         mcand    <= '0;
         mplier   <= '0;
         iter     <= '0;
         sticky_r <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  exp_w    <= $signed(XEXP_W'(exp_a) + XEXP_W'(exp_b) - XEXP_W'(BIAS));
                  sticky_r <= 1'b0;
                  state    <= ST_PRENORM;
               end
            end
            ST_PRENORM: begin
               if (rdy_a && rdy_b) begin
                  mplier <= mant_a;
                  mcand  <= mant_b;
                  acc    <= '0;
                  iter   <= '0;
                  state  <= ST_LOOP;
               end else begin
                  exp_w <= exp_w - $signed({{(XEXP_W-2){1'b0}}, nshift});
               end
            end
            ST_LOOP: begin
               acc      <= acc_nxt;
               sticky_r <= sticky_r | drop;
               mplier   <= mplier >> DIGIT;
               iter     <= iter + 1'b1;
               if (iter == CNT_W'(ITER - 1)) state <= ST_FIX;
            end
            ST_FIX: begin
               if (acc[LEAD]) exp_w <= exp_w + XEXP_W'(1);
               else           acc   <= acc << 1;
               state <= ST_POSTNORM;
            end
            ST_POSTNORM: begin
               if (acc[LEAD]) begin
                  state <= ST_DONE;
               end else begin
                  acc   <= acc << 1;
                  exp_w <= exp_w - XEXP_W'(1);
               end
            end
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);
   assign prod_mant = acc[LEAD:RES_LSB];
   assign prod_exp  = exp_w;
   assign guard     = acc[GUARD_SH];
   assign sticky    = sticky_r | (|acc[GUARD_SH-1:0]);

   // R2: an accepted start raises busy in the next cycle
   a_r2_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R3: done never lasts two cycles
   a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: the result field carries its leading one at completion
   a_r8_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> prod_mant[MANT_W-1]);
   // R6: both significands are normalized when the loop begins
   a_r6_loop_inputs_normal: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOOP && iter == '0) |-> (mcand[MANT_W-1] && mplier[MANT_W-1]));
   // R10: all multiplier digits are consumed when the loop exits
   a_r10_mplier_drained: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIX) |-> (mplier == '0));
   // R10: a dropped bit is never forgotten within one operation
   a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state != ST_PRENORM && $past(sticky_r)) |-> sticky_r);
   // R6: a subnormal operand must carry a nonzero fraction
   a_r6_nonzero_a: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && exp_a == '0) |-> (frac_a != '0));
   a_r6_nonzero_b: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && exp_b == '0) |-> (frac_b != '0));
endmodule

// File: tb/r16_sig_mul_tb.sv
module r16_sig_mul_tb;
   typedef struct packed {
      logic [51:0] fa;
      logic [10:0] ea;
      logic [51:0] fb;
      logic [10:0] eb;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VEC [NVEC] = '{
      '{52'h0000000000000, 11'd1023, 52'h0000000000000, 11'd1023},
      '{52'h8000000000000, 11'd1023, 52'h8000000000000, 11'd1023},
      '{52'hFFFFFFFFFFFFF, 11'd2046, 52'hFFFFFFFFFFFFF, 11'd2046},
      '{52'h0000000000001, 11'd0,    52'h0000000000000, 11'd1},
      '{52'h0000000000001, 11'd0,    52'h8000000000000, 11'd0},
      '{52'hA5A5A5A5A5A5A, 11'd1000, 52'h123456789ABCD, 11'd1100},
      '{52'hFFFFFFFFFFFFF, 11'd5,    52'h0000000000001, 11'd7},
      '{52'h0F0F0F0F0F0F0, 11'd0,    52'h3333333333333, 11'd2000},
      '{52'h0000000000000, 11'd1023, 52'h0000000000001, 11'd1023},
      '{52'h0000000000001, 11'd1023, 52'h0000000000001, 11'd1023}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [51:0] frac_a = '0, frac_b = '0;
   logic [10:0] exp_a = '0, exp_b = '0;
   logic busy, done, guard, sticky;
   logic [52:0] prod_mant;
   logic signed [13:0] prod_exp;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   r16_sig_mul u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .frac_a(frac_a), .exp_a(exp_a), .frac_b(frac_b), .exp_b(exp_b),
      .busy(busy), .done(done), .prod_mant(prod_mant), .prod_exp(prod_exp),
      .guard(guard), .sticky(sticky));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int clz52(input logic [51:0] f);
      int n = 0;
      for (int i = 51; i >= 0; i--) begin
         if (f[i]) break;
         n++;
      end
      return n;
   endfunction

   task automatic ref_model(input vec_t v, output logic [52:0] m, output int e,
                            output logic g, output logic s, output int lat);
      logic [52:0] ma, mb;
      logic [105:0] p;
      int za = 0, zb = 0;
      if (v.ea != 0) ma = {1'b1, v.fa};
      else begin za = clz52(v.fa); ma = {v.fa, 1'b0} << za; end
      if (v.eb != 0) mb = {1'b1, v.fb};
      else begin zb = clz52(v.fb); mb = {v.fb, 1'b0} << zb; end
      e = int'(v.ea) + int'(v.eb) - 1023 - za - zb;
      p = {53'b0, ma} * {53'b0, mb};
      if (p[105]) begin
         m = p[105:53]; g = p[52]; s = |p[51:0]; e = e + 1;
      end else begin
         m = p[104:52]; g = p[51]; s = |p[50:0];
      end
      lat = 17 + ((za > zb) ? za : zb);
   endtask

   // Launch one operation; optionally pulse start again while busy.
   task automatic run_op(input vec_t v, input bit poke, output int lat, output bit busy_ok);
      int n = 0;
      busy_ok = 1'b1;
      @(negedge clk);
      frac_a = v.fa; exp_a = v.ea; frac_b = v.fb; exp_b = v.eb;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 400) begin
         if (!busy) busy_ok = 1'b0;
         if (poke && n == 5) begin
            start = 1'b1; frac_a = 52'h1111111111111; exp_a = 11'd3;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      if (!done) begin
         fails++;
         $display("FAIL R2: actual no done expected done within 400 cycles");
      end
      lat = n;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [52:0] m; int e, lat, rlat; logic g, s; bit bok;
      logic [52:0] hold_m; logic [13:0] hold_e;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", 64'(busy), 64'd0);
      chk("R1 done in reset", 64'(done), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", 64'(busy), 64'd0);
      chk("R1 done after reset", 64'(done), 64'd0);

      // Table walk: R5 R6 R7 R8 R9 R10 R4
      for (int i = 0; i < NVEC; i++) begin
         ref_model(VEC[i], m, e, g, s, rlat);
         run_op(VEC[i], 1'b0, lat, bok);
         chk($sformatf("R8 mant vec%0d", i), 64'(prod_mant), 64'(m));
         chk($sformatf("R7 exp vec%0d", i), 64'(int'(prod_exp)), 64'(e));
         chk($sformatf("R9 guard vec%0d", i), 64'(guard), 64'(g));
         chk($sformatf("R10 sticky vec%0d", i), 64'(sticky), 64'(s));
         chk($sformatf("R4/R6 latency vec%0d", i), 64'(lat), 64'(rlat));
         chk($sformatf("R2 busy span vec%0d", i), 64'(bok), 64'd1);
      end

      // Hand-computed corners: R5 unity, R7 product >= 2, R10 low bit
      run_op(VEC[0], 1'b0, lat, bok);
      chk("R5 unity mant", 64'(prod_mant), 64'h10000000000000);
      chk("R5 unity exp", 64'(int'(prod_exp)), 64'd1023);
      run_op(VEC[1], 1'b0, lat, bok);
      chk("R7 carry exp", 64'(int'(prod_exp)), 64'd1024);
      chk("R7 carry mant", 64'(prod_mant), 64'h12000000000000);
      run_op(VEC[9], 1'b0, lat, bok);
      chk("R8 low mant", 64'(prod_mant), 64'h10000000000002);
      chk("R9 low guard", 64'(guard), 64'd0);
      chk("R10 low sticky", 64'(sticky), 64'd1);

      // R3: done pulse width and result hold
      hold_m = prod_mant; hold_e = prod_exp;
      @(negedge clk);
      chk("R3 done one cycle", 64'(done), 64'd0);
      chk("R2 idle after done", 64'(busy), 64'd0);
      repeat (3) @(negedge clk);
      chk("R3 mant held", 64'(prod_mant), 64'(hold_m));
      chk("R3 exp held", 64'(prod_exp), 64'(hold_e));

      // R2: start during busy is ignored
      ref_model(VEC[5], m, e, g, s, rlat);
      run_op(VEC[5], 1'b1, lat, bok);
      chk("R2 poke mant", 64'(prod_mant), 64'(m));
      chk("R2 poke exp", 64'(int'(prod_exp)), 64'(e));
      chk("R2 poke latency", 64'(lat), 64'(rlat));
      @(negedge clk);
      chk("R2 no second run", 64'(busy), 64'd0);

      // R1: reset mid-operation
      @(negedge clk);
      frac_a = VEC[2].fa; exp_a = VEC[2].ea; frac_b = VEC[2].fb; exp_b = VEC[2].eb;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after mid reset", 64'(busy), 64'd0);
      repeat (20) @(negedge clk);
      chk("R1 no done after mid reset", 64'(done), 64'd0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule